// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the software-facing register file and control logic of an SMBus master. A byte-wide I/O port reaches a small set of byte registers: a target register (7-bit address plus read flag), a command byte, two data bytes, a block-data byte, a packet-error-code byte, an auxiliary control register and the control and status registers. Software fills in the target, command and data, then writes the control register with a transaction code and the start bit. The block hands the request to a separate bus engine that does the SCL/SDA timing. The engine reports back, and the block turns that report into sticky status flags.

Status flags are cleared by writing a one to their bit. A host-busy bit shows that a transaction is in flight. A kill bit in the control register aborts the transaction in flight and reports it as failed. Read results from the engine go into the data registers when the transaction type and direction call for them. The interrupt output is raised while any completion or error flag is pending.

Top module: `smbh_host_regs`

## Requirements
- R1: After reset, every register reads 0, except that status bit 5 follows the alert input. Host-busy is clear, the interrupt output is low and no engine start or abort pulse is issued.
- R2: The byte registers read back what was written: command at offset 3, target at 4, data0 at 5, data1 at 6, block data at 7 and the code byte at 8. Auxiliary control at offset 13 keeps only bits 1:0. The control register at offset 2 reads back bits 7, 5, 4:2 and 1, while the start bit 6 and bit 0 read 0. Offsets that are not mapped read 0.
- R3: A control write with bit 6 set and bit 1 clear while idle sets host-busy (status bit 0) at the next edge and issues a one-cycle engine start pulse. The engine sees the transaction code (control bits 4:2: 0 quick, 1 byte, 2 byte-data, 3 word, 4 process call, 5 block, 6 I2C block), the target address (target bits 7:1), the read flag (target bit 0), the last-byte flag (control bit 5) and the command byte.
- R4: A start written while host-busy is set is ignored. No new start pulse is issued and the transaction code the engine sees does not change.
- R5: When the engine reports done without error while busy, host-busy clears and the interrupt flag (status bit 1) sets. The interrupt output is high while any of status bits 1 to 4 is set.
- R6: A done report carrying a no-acknowledge error sets status bit 2, and one carrying lost arbitration sets status bit 3. Neither sets the interrupt flag, and both clear host-busy.
- R7: On successful completion, data0 takes the engine's first returned byte for byte, byte-data and word reads, and for process calls. Data1 takes the second returned byte only for word reads and process calls. Writes and failed transactions leave both data registers unchanged.
- R8: A control write with bit 1 set while busy clears host-busy, sets the failed flag (status bit 4) and issues a one-cycle engine abort pulse. A later done report from the engine is ignored. A start written together with kill while idle is ignored.
- R9: Writing 1 to status bits 7, 4, 3, 2 or 1 clears them, and writing 0 leaves them set. Busy (bit 0) and alert (bit 5) cannot be written. When a flag is set and cleared in the same cycle, it ends up set.
- R10: A byte-done report from the engine while busy sets status bit 7.
- R11: Auxiliary control bit 1 drives the block-buffer mode output. Auxiliary control bit 0 forces the code-check request to the engine, which is otherwise taken from control bit 7.
- R12: Status bit 5 reflects the alert input level, and status bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| alert_in | input | 1 | Alert line level from the bus side |
| irq | output | 1 | Completion/error pending |
| eng_start | output | 1 | One-cycle request to the bus engine |
| eng_abort | output | 1 | One-cycle abort to the bus engine |
| eng_xtype | output | 3 | Transaction code |
| eng_pec | output | 1 | Code-check requested |
| eng_last | output | 1 | Last-byte flag |
| eng_target | output | 7 | Target address |
| eng_rnw | output | 1 | Read flag |
| eng_cmd | output | 8 | Command byte |
| eng_wdata0 | output | 8 | Data0 register |
| eng_wdata1 | output | 8 | Data1 register |
| eng_blk_byte | output | 8 | Block-data register |
| eng_pec_byte | output | 8 | Code byte register |
| eng_blk_mode | output | 1 | Block-buffer mode enable |
| eng_done | input | 1 | Engine finished the transaction |
| eng_dev_err | input | 1 | No-acknowledge, valid with eng_done |
| eng_bus_err | input | 1 | Lost arbitration, valid with eng_done |
| eng_byte_done | input | 1 | One byte moved |
| eng_rx0 | input | 8 | First returned byte, valid with eng_done |
| eng_rx1 | input | 8 | Second returned byte, valid with eng_done |

## Verification
The host-busy state is the pivot. If it is wrong, a second start pulse escapes to the engine, or a done report is dropped. Either shows at the ports within one cycle, because eng_start, the status read and irq all change at the edge after the triggering write or report. Wrong sticky flags show on the next status read, and a wrong load rule shows as a data register that does or does not take the returned bytes right after completion. Set-versus-clear collisions and kill-then-done are driven directly, because a wrong priority there only shows in those cycles.

// File: rtl/smbh_pkg.sv
// Package: shared offsets, transaction codes and bit positions for the
// SMBus host register front-end. Assumes byte-wide registers.
package smbh_pkg;

    // Register byte offsets
    localparam int OFF_STAT = 0;
    localparam int OFF_CTRL = 2;
    localparam int OFF_CMD  = 3;
    localparam int OFF_TGT  = 4;
    localparam int OFF_D0   = 5;
    localparam int OFF_D1   = 6;
    localparam int OFF_BLK  = 7;
    localparam int OFF_PEC  = 8;
    localparam int OFF_AUXS = 12;
    localparam int OFF_AUXC = 13;

    // Plain byte registers occupy a contiguous offset range
    localparam int PLAIN_BASE = OFF_CMD;
    localparam int PLAIN_CNT  = OFF_PEC - OFF_CMD + 1;

    // Status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_INTR  = 1;
    localparam int ST_DEV   = 2;
    localparam int ST_BUS   = 3;
    localparam int ST_FAIL  = 4;
    localparam int ST_ALERT = 5;
    localparam int ST_INUSE = 6;
    localparam int ST_BDONE = 7;

    // Sticky write-one-to-clear flags
    localparam logic [7:0] STICKY_MASK = 8'b1001_1110;

    // Control bit positions
    localparam int CT_KILL  = 1;
    localparam int CT_TYLO  = 2;
    localparam int CT_LAST  = 5;
    localparam int CT_START = 6;
    localparam int CT_PEC   = 7;

    typedef enum logic [2:0] {
        XT_QUICK = 3'd0,
        XT_BYTE  = 3'd1,
        XT_BDATA = 3'd2,
        XT_WORD  = 3'd3,
        XT_PCALL = 3'd4,
        XT_BLOCK = 3'd5,
        XT_I2CB  = 3'd6,
        XT_RSVD  = 3'd7
    } xtype_e;

    typedef struct packed {
        logic   pec;
        logic   last;
        xtype_e xtype;
        logic   kill;
    } ctrl_t;

endpackage

// File: rtl/smbh_regfile.sv
// Register file: plain byte registers, the control fields and auxiliary
// control. Assumes the sequencer supplies busy; while busy only the kill and
// last fields of control may change. Engine loads win over software writes.
module smbh_regfile
    import smbh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NPLAIN = PLAIN_CNT,
    parameter int AUXW = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_off,
    input  logic [DW-1:0]            wr_data,
    input  logic                     busy,
    input  logic [NPLAIN-1:0]        load_vec,
    input  logic [NPLAIN-1:0][DW-1:0] load_val,
    output logic [NPLAIN-1:0][DW-1:0] plain_q,
    output ctrl_t                    ctrl_q,
    output logic [AUXW-1:0]          aux_q
);

    // One byte register per contiguous plain offset
    for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
        localparam logic [AW-1:0] MY_OFF = AW'(PLAIN_BASE + i);
        logic hit;
        assign hit = wr_en && (wr_off == MY_OFF);

        // Byte register update: engine load, else software write
        always_ff @(posedge clk) begin
            if (!rst_n)             plain_q[i] <= '0;
            else if (load_vec[i])   plain_q[i] <= load_val[i];
            else if (hit)           plain_q[i] <= wr_data;
        end
    end

    logic ctrl_hit;
    logic aux_hit;
    assign ctrl_hit = wr_en && (wr_off == AW'(OFF_CTRL));
    assign aux_hit  = wr_en && (wr_off == AW'(OFF_AUXC));

    // Control fields: full update while idle, kill/last only while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_hit) begin
            ctrl_q.kill <= wr_data[CT_KILL];
            ctrl_q.last <= wr_data[CT_LAST];
            if (!busy) begin
                ctrl_q.pec   <= wr_data[CT_PEC];
                ctrl_q.xtype <= xtype_e'(wr_data[CT_TYLO +: 3]);
            end
        end
    end

    // Auxiliary control keeps its low AUXW bits
    always_ff @(posedge clk) begin
        if (!rst_n)       aux_q <= '0;
        else if (aux_hit) aux_q <= wr_data[AUXW-1:0];
    end

endmodule

// File: rtl/smbh_seq.sv
// Sequencer: owns host-busy, accepts start, applies kill, and turns engine
// reports into one-cycle flag-set events. Assumes the engine raises done at
// most once per start; reports while idle are dropped.
module smbh_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_start,
    input  logic wr_kill,
    input  logic eng_done,
    input  logic eng_dev_err,
    input  logic eng_bus_err,
    input  logic eng_byte_done,
    output logic busy,
    output logic eng_start,
    output logic eng_abort,
    output logic ev_intr,
    output logic ev_dev,
    output logic ev_bus,
    output logic ev_fail,
    output logic ev_bdone
);

    logic kill_now;
    logic start_ok;
    logic done_ok;

    assign kill_now = ctrl_wr && wr_kill && busy;
    assign start_ok = ctrl_wr && wr_start && !wr_kill && !busy;
    assign done_ok  = eng_done && busy && !kill_now;

    // Busy state and one-cycle engine request/abort pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
        end else begin
            eng_start <= start_ok;
            eng_abort <= kill_now;
            if (start_ok)                 busy <= 1'b1;
            else if (kill_now || done_ok) busy <= 1'b0;
        end
    end

    // Flag-set events derived from the same-cycle engine report
    always_comb begin
        ev_fail  = kill_now;
        ev_dev   = done_ok && eng_dev_err;
        ev_bus   = done_ok && eng_bus_err;
        ev_intr  = done_ok && !eng_dev_err && !eng_bus_err;
        ev_bdone = eng_byte_done && busy && !kill_now;
    end

endmodule

// File: rtl/smbh_status.sv
// Status flags: one sticky write-one-to-clear bit per set position in MASK;
// other positions are tied low. A set in the clearing cycle wins.
module smbh_status #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = 8'b1001_1110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] flags
);

    for (genvar i = 0; i < W; i++) begin : g_flag
        if (MASK[i]) begin : g_sticky
            // Sticky flag with set priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)          flags[i] <= 1'b0;
                else if (set_vec[i]) flags[i] <= 1'b1;
                else if (clr_wr && clr_data[i]) flags[i] <= 1'b0;
            end
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/smbh_host_regs.sv
// Top: SMBus host register front-end. Decodes the byte bus, routes the
// engine request fields, selects result loads and muxes read data.
// Assumes reads have no side effects and bus_rdata is sampled combinationally.
module smbh_host_regs
    import smbh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          alert_in,
    output logic          irq,
    output logic          eng_start,
    output logic          eng_abort,
    output logic [2:0]    eng_xtype,
    output logic          eng_pec,
    output logic          eng_last,
    output logic [6:0]    eng_target,
    output logic          eng_rnw,
    output logic [DW-1:0] eng_cmd,
    output logic [DW-1:0] eng_wdata0,
    output logic [DW-1:0] eng_wdata1,
    output logic [DW-1:0] eng_blk_byte,
    output logic [DW-1:0] eng_pec_byte,
    output logic          eng_blk_mode,
    input  logic          eng_done,
    input  logic          eng_dev_err,
    input  logic          eng_bus_err,
    input  logic          eng_byte_done,
    input  logic [DW-1:0] eng_rx0,
    input  logic [DW-1:0] eng_rx1
);

    localparam int NPLAIN = PLAIN_CNT;
    localparam int I_CMD  = OFF_CMD - PLAIN_BASE;
    localparam int I_TGT  = OFF_TGT - PLAIN_BASE;
    localparam int I_D0   = OFF_D0  - PLAIN_BASE;
    localparam int I_D1   = OFF_D1  - PLAIN_BASE;
    localparam int I_BLK  = OFF_BLK - PLAIN_BASE;
    localparam int I_PEC  = OFF_PEC - PLAIN_BASE;
    localparam int AUXW   = 2;

    logic                      busy;
    logic                      ev_intr, ev_dev, ev_bus, ev_fail, ev_bdone;
    logic [NPLAIN-1:0]         load_vec;
    logic [NPLAIN-1:0][DW-1:0] load_val;
    logic [NPLAIN-1:0][DW-1:0] plain_q;
    ctrl_t                     ctrl_q;
    logic [AUXW-1:0]           aux_q;
    logic [7:0]                set_vec;
    logic [7:0]                st_flags;
    logic                      ctrl_wr;
    logic                      stat_wr;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(OFF_CTRL));
    assign stat_wr = bus_wr && (bus_addr == AW'(OFF_STAT));

    smbh_seq seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .wr_start      (bus_wdata[CT_START]),
        .wr_kill       (bus_wdata[CT_KILL]),
        .eng_done      (eng_done),
        .eng_dev_err   (eng_dev_err),
        .eng_bus_err   (eng_bus_err),
        .eng_byte_done (eng_byte_done),
        .busy          (busy),
        .eng_start     (eng_start),
        .eng_abort     (eng_abort),
        .ev_intr       (ev_intr),
        .ev_dev        (ev_dev),
        .ev_bus        (ev_bus),
        .ev_fail       (ev_fail),
        .ev_bdone      (ev_bdone)
    );

    // Result load selection: which data registers take returned bytes
    always_comb begin
        logic rd_one;
        logic rd_two;
        rd_one = (plain_q[I_TGT][0] &&
                  (ctrl_q.xtype == XT_BYTE || ctrl_q.xtype == XT_BDATA ||
                   ctrl_q.xtype == XT_WORD)) || ctrl_q.xtype == XT_PCALL;
        rd_two = (plain_q[I_TGT][0] && ctrl_q.xtype == XT_WORD) ||
                 ctrl_q.xtype == XT_PCALL;
        load_vec        = '0;
        load_val        = '0;
        load_vec[I_D0]  = ev_intr && rd_one;
        load_vec[I_D1]  = ev_intr && rd_two;
        load_val[I_D0]  = eng_rx0;
        load_val[I_D1]  = eng_rx1;
    end

    smbh_regfile #(.AW(AW), .DW(DW), .NPLAIN(NPLAIN), .AUXW(AUXW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_off   (bus_addr),
        .wr_data  (bus_wdata),
        .busy     (busy),
        .load_vec (load_vec),
        .load_val (load_val),
        .plain_q  (plain_q),
        .ctrl_q   (ctrl_q),
        .aux_q    (aux_q)
    );

    // Flag-set vector in status bit order
    always_comb begin
        set_vec           = '0;
        set_vec[ST_INTR]  = ev_intr;
        set_vec[ST_DEV]   = ev_dev;
        set_vec[ST_BUS]   = ev_bus;
        set_vec[ST_FAIL]  = ev_fail;
        set_vec[ST_BDONE] = ev_bdone;
    end

    smbh_status #(.W(8), .MASK(STICKY_MASK)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (stat_wr),
        .clr_data (bus_wdata[7:0]),
        .flags    (st_flags)
    );

    // Engine-facing request fields
    always_comb begin
        eng_xtype    = ctrl_q.xtype;
        eng_pec      = ctrl_q.pec || aux_q[0];
        eng_last     = ctrl_q.last;
        eng_target   = plain_q[I_TGT][7:1];
        eng_rnw      = plain_q[I_TGT][0];
        eng_cmd      = plain_q[I_CMD];
        eng_wdata0   = plain_q[I_D0];
        eng_wdata1   = plain_q[I_D1];
        eng_blk_byte = plain_q[I_BLK];
        eng_pec_byte = plain_q[I_PEC];
        eng_blk_mode = aux_q[1];
        irq          = st_flags[ST_INTR] || st_flags[ST_DEV] ||
                       st_flags[ST_BUS]  || st_flags[ST_FAIL];
    end

    // Read data multiplexer
    always_comb begin
        logic [7:0] stat_b;
        stat_b           = st_flags;
        stat_b[ST_BUSY]  = busy;
        stat_b[ST_ALERT] = alert_in;
        stat_b[ST_INUSE] = 1'b0;
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_STAT)) begin
            bus_rdata = DW'(stat_b);
        end else if (bus_addr == AW'(OFF_CTRL)) begin
            bus_rdata = DW'({ctrl_q.pec, 1'b0, ctrl_q.last, ctrl_q.xtype,
                             ctrl_q.kill, 1'b0});
        end else if (bus_addr >= AW'(PLAIN_BASE) &&
                     bus_addr <= AW'(PLAIN_BASE + NPLAIN - 1)) begin
            bus_rdata = plain_q[bus_addr - AW'(PLAIN_BASE)];
        end else if (bus_addr == AW'(OFF_AUXC)) begin
            bus_rdata = DW'(aux_q);
        end
    end

endmodule

// File: rtl/smbh_host_regs_chk.sv
// Checker: temporal properties of the host front-end, bound to the top.
module smbh_host_regs_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          busy,
    input logic [7:0]    st_flags,
    input logic          eng_start,
    input logic          eng_abort,
    input logic          eng_done,
    input logic          eng_dev_err,
    input logic          eng_bus_err
);

    logic kill_wr;
    assign kill_wr = bus_wr && (bus_addr == AW'(2)) && bus_wdata[1];

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    assert_no_start_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(busy));

    assert_done_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy && !eng_dev_err && !eng_bus_err && !kill_wr)
        |=> (!busy && st_flags[1]));

    assert_dev_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy && eng_dev_err && !kill_wr) |=> (!busy && st_flags[2]));

    assert_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_wr && busy) |=> (!busy && st_flags[4] && eng_abort));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !busy);

endmodule

bind smbh_host_regs smbh_host_regs_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .st_flags    (st_flags),
    .eng_start   (eng_start),
    .eng_abort   (eng_abort),
    .eng_done    (eng_done),
    .eng_dev_err (eng_dev_err),
    .eng_bus_err (eng_bus_err)
);

// File: tb/smbh_host_regs_tb.sv
// Bench: directed corner cases plus seeded random transactions.
module smbh_host_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alert_in = 1'b0;
    logic       irq;
    logic       eng_start, eng_abort, eng_pec, eng_last, eng_rnw, eng_blk_mode;
    logic [2:0] eng_xtype;
    logic [6:0] eng_target;
    logic [7:0] eng_cmd, eng_wdata0, eng_wdata1, eng_blk_byte, eng_pec_byte;
    logic       eng_done = 1'b0, eng_dev_err = 1'b0, eng_bus_err = 1'b0;
    logic       eng_byte_done = 1'b0;
    logic [7:0] eng_rx0 = '0, eng_rx1 = '0;

    int total = 0;
    int bad = 0;
    int starts = 0;
    int aborts = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    smbh_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_in(alert_in),
        .irq(irq), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_xtype(eng_xtype), .eng_pec(eng_pec), .eng_last(eng_last),
        .eng_target(eng_target), .eng_rnw(eng_rnw), .eng_cmd(eng_cmd),
        .eng_wdata0(eng_wdata0), .eng_wdata1(eng_wdata1),
        .eng_blk_byte(eng_blk_byte), .eng_pec_byte(eng_pec_byte),
        .eng_blk_mode(eng_blk_mode), .eng_done(eng_done),
        .eng_dev_err(eng_dev_err), .eng_bus_err(eng_bus_err),
        .eng_byte_done(eng_byte_done), .eng_rx0(eng_rx0), .eng_rx1(eng_rx1)
    );

    // Count engine pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n && eng_start) starts++;
        if (rst_n && eng_abort) aborts++;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_xact(input logic dev, input logic busl, input logic [7:0] r0, input logic [7:0] r1);
        @(negedge clk);
        eng_done = 1'b1; eng_dev_err = dev; eng_bus_err = busl;
        eng_rx0 = r0; eng_rx1 = r1;
        @(negedge clk);
        eng_done = 1'b0; eng_dev_err = 1'b0; eng_bus_err = 1'b0;
    endtask

    function automatic logic [7:0] stat_of(input logic bdone, input logic alert,
        input logic fail, input logic busl, input logic dev, input logic intr, input logic bsy);
        return {bdone, 1'b0, alert, fail, busl, dev, intr, bsy};
    endfunction

    function automatic logic [7:0] ctrl_of(input logic pec, input logic start,
        input logic last, input logic [2:0] xt, input logic kill);
        return {pec, start, last, xt, kill, 1'b0};
    endfunction

    function automatic bit loads_d0(input logic rnw, input logic [2:0] xt);
        return (rnw && (xt == 3'd1 || xt == 3'd2 || xt == 3'd3)) || xt == 3'd4;
    endfunction

    function automatic bit loads_d1(input logic rnw, input logic [2:0] xt);
        return (rnw && xt == 3'd3) || xt == 3'd4;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] d0_m, d1_m;
        int s0;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'd0, v);  check("R1 status", v, 8'h00);
        rd(4'd2, v);  check("R1 ctrl", v, 8'h00);
        rd(4'd5, v);  check("R1 data0", v, 8'h00);
        rd(4'd13, v); check("R1 auxctl", v, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 start pulses", starts, 0);

        // R2: register decode and read-back
        wr(4'd3, 8'h5A); wr(4'd4, 8'hA3); wr(4'd5, 8'h11); wr(4'd6, 8'h22);
        wr(4'd7, 8'h33); wr(4'd8, 8'h44); wr(4'd13, 8'hFF); wr(4'd1, 8'hEE);
        rd(4'd3, v);  check("R2 cmd", v, 8'h5A);
        rd(4'd4, v);  check("R2 target", v, 8'hA3);
        rd(4'd5, v);  check("R2 data0", v, 8'h11);
        rd(4'd6, v);  check("R2 data1", v, 8'h22);
        rd(4'd7, v);  check("R2 blk", v, 8'h33);
        rd(4'd8, v);  check("R2 pecbyte", v, 8'h44);
        rd(4'd13, v); check("R2 auxctl low bits", v, 8'h03);
        rd(4'd1, v);  check("R2 unmapped", v, 8'h00);
        rd(4'd12, v); check("R2 auxsts", v, 8'h00);
        wr(4'd2, 8'hAD);
        rd(4'd2, v);  check("R2 ctrl readback", v, 8'hAC);

        // R11: aux control forces code check and block mode
        wr(4'd2, 8'h00);
        check("R11 blk mode", eng_blk_mode, 1'b1);
        check("R11 pec forced", eng_pec, 1'b1);
        wr(4'd13, 8'h00);
        check("R11 blk mode off", eng_blk_mode, 1'b0);
        check("R11 pec off", eng_pec, 1'b0);
        check("R11 engine sees block byte", eng_blk_byte, 8'h33);

        // R3: start while idle (byte-data read to 0x28)
        wr(4'd4, 8'h51);
        s0 = starts;
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b1, 3'd2, 1'b0));
        check("R3 start pulse", eng_start, 1'b1);
        rd(4'd0, v);  check("R3 busy", v, 8'h01);
        check("R3 xtype", eng_xtype, 3'd2);
        check("R3 target", eng_target, 7'h28);
        check("R3 rnw", eng_rnw, 1'b1);
        check("R3 last", eng_last, 1'b1);
        check("R3 cmd", eng_cmd, 8'h5A);
        @(negedge clk);
        check("R3 pulse one cycle", eng_start, 1'b0);
        check("R3 one start", starts - s0, 1);

        // R4: start while busy ignored
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd3, 1'b0));
        @(negedge clk);
        check("R4 no second start", starts - s0, 1);
        check("R4 xtype held", eng_xtype, 3'd2);

        // R5 / R7: successful byte-data read
        finish_xact(1'b0, 1'b0, 8'h77, 8'h88);
        rd(4'd0, v);  check("R5 intr set busy clear", v, stat_of(0,0,0,0,0,1,0));
        check("R5 irq", irq, 1'b1);
        rd(4'd5, v);  check("R7 data0 loaded", v, 8'h77);
        rd(4'd6, v);  check("R7 data1 kept", v, 8'h22);

        // R9: write-one-to-clear
        wr(4'd0, 8'h00);
        rd(4'd0, v);  check("R9 zero write keeps", v, 8'h02);
        wr(4'd0, 8'h02);
        rd(4'd0, v);  check("R9 clear intr", v, 8'h00);
        check("R9 irq low", irq, 1'b0);
        wr(4'd0, 8'h01);
        rd(4'd0, v);  check("R9 busy not writable", v, 8'h00);

        // R6: device error on quick write, then lost arbitration
        wr(4'd4, 8'h50);
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd0, 1'b0));
        finish_xact(1'b1, 1'b0, 8'hCC, 8'hDD);
        rd(4'd0, v);  check("R6 dev err", v, 8'h04);
        rd(4'd5, v);  check("R7 no load on error", v, 8'h77);
        wr(4'd0, 8'h04);
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd1, 1'b0));
        finish_xact(1'b0, 1'b1, 8'hCC, 8'hDD);
        rd(4'd0, v);  check("R6 bus err", v, 8'h08);
        check("R6 irq", irq, 1'b1);
        wr(4'd0, 8'hFF);

        // R8: kill while busy, then stale done
        s0 = aborts;
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd1, 1'b0));
        wr(4'd2, ctrl_of(1'b0, 1'b0, 1'b0, 3'd1, 1'b1));
        check("R8 abort pulse", eng_abort, 1'b1);
        rd(4'd0, v);  check("R8 failed busy clear", v, 8'h10);
        finish_xact(1'b0, 1'b0, 8'h99, 8'h99);
        rd(4'd0, v);  check("R8 stale done ignored", v, 8'h10);
        check("R8 one abort", aborts - s0, 1);
        wr(4'd0, 8'h10);
        s0 = starts;
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd1, 1'b1));
        @(negedge clk);
        check("R8 start with kill ignored", starts - s0, 0);
        rd(4'd0, v);  check("R8 idle after kill start", v, 8'h00);
        wr(4'd2, 8'h00);

        // R10 / R9: byte-done and set-over-clear collision
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd5, 1'b0));
        @(negedge clk); eng_byte_done = 1'b1;
        @(negedge clk); eng_byte_done = 1'b0;
        rd(4'd0, v);  check("R10 byte done", v, 8'h81);
        wr(4'd0, 8'h80);
        rd(4'd0, v);  check("R9 clear byte done", v, 8'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h80; eng_byte_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_byte_done = 1'b0;
        rd(4'd0, v);  check("R9 set wins over clear", v, 8'h81);
        finish_xact(1'b0, 1'b0, 8'h00, 8'h00);
        wr(4'd0, 8'hFF);

        // R12: alert level, not clearable, in-use reads 0
        alert_in = 1'b1;
        wr(4'd0, 8'h60);
        rd(4'd0, v);  check("R12 alert level", v, 8'h20);
        alert_in = 1'b0;
        rd(4'd0, v);  check("R12 alert follows", v, 8'h00);

        // R7: word read loads both; write leaves data
        wr(4'd4, 8'h21);
        wr(4'd2, ctrl_of(1'b0, 1'b1, 1'b0, 3'd3, 1'b0));
        finish_xact(1'b0, 1'b0, 8'h12, 8'h34);
        rd(4'd5, v);  check("R7 word lo", v, 8'h12);
        rd(4'd6, v);  check("R7 word hi", v, 8'h34);
        wr(4'd0, 8'hFF);

        // Random transactions (R3, R5, R6, R7)
        rd(4'd5, d0_m); rd(4'd6, d1_m);
        for (int n = 0; n < 60; n++) begin
            logic [7:0] tg, cm;
            logic [2:0] xt;
            logic       pc;
            int         es;
            logic [7:0] r0, r1, exps;
            tg = 8'($urandom); cm = 8'($urandom);
            xt = 3'($urandom % 7); pc = 1'($urandom);
            es = int'($urandom % 3);
            r0 = 8'($urandom); r1 = 8'($urandom);
            wr(4'd4, tg); wr(4'd3, cm);
            wr(4'd2, ctrl_of(pc, 1'b1, 1'b0, xt, 1'b0));
            check("R3 rand fields", {eng_start, eng_xtype, eng_pec, eng_target, eng_rnw, eng_cmd},
                  {1'b1, xt, pc, tg[7:1], tg[0], cm});
            repeat (int'($urandom % 4)) @(negedge clk);
            finish_xact(es == 1, es == 2, r0, r1);
            if (es == 0) begin
                if (loads_d0(tg[0], xt)) d0_m = r0;
                if (loads_d1(tg[0], xt)) d1_m = r1;
                exps = 8'h02;
            end else begin
                exps = (es == 1) ? 8'h04 : 8'h08;
            end
            rd(4'd0, v);  check("R5 R6 rand status", v, exps);
            rd(4'd5, v);  check("R7 rand data0", v, d0_m);
            rd(4'd6, v);  check("R7 rand data1", v, d1_m);
            wr(4'd0, 8'hFF);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule